// File: doc/BRIEF.md
# Three-Port Pipelined Vector Adder

This block adds two vectors of 16-bit words element by element and writes the sums to a third memory. It has two independent read ports, one for each operand vector, and one write-only port for the result vector. A `start` pulse latches the three base addresses and the element count. The engine then runs the whole vector without any further control input.

The work is software-pipelined over the three ports. One prologue cycle fetches the first pair of operands. In every following cycle, the adder sums the pair that has just returned, the write port stores that sum, and both read ports fetch the next pair. A final epilogue cycle stores the last sum and issues no read. A hardware down-counter moves the engine through these phases, so no cycle is spent on loop control. The operation takes N+2 cycles in total, counting the cycle in which `start` is sampled. For the common length of 40, that is 42 cycles.

The memory ports have fixed timing and no back-pressure. Each read returns its data in the cycle after the request is presented, and each write is taken in the cycle it is presented. The downstream memory must accept one write per cycle.

Top module: `vadd_engine`

## Requirements
- R1: Each stored result equals the sum of the two operand words modulo 2^16. The carry out is dropped, so 0xFFFF + 0x0001 stores 0x0000 and 0x8000 + 0x8000 stores 0x0000.
- R2: Starting a non-empty operation works as follows. Let the cycle in which `start` is sampled high with `busy` low be cycle 0. In cycle 1, both read ports present element 0 with their enables high together, and no write is presented.
- R3: In cycles 2 through N, both read ports fetch element k-1 and the write port stores result k-2, all in the same cycle.
- R4: In cycle N+1, the last result (element N-1) is written with both read enables low. Each read port issues exactly N requests per operation, and the write port issues exactly N writes.
- R5: `busy` is high in cycles 1 through N+1 exactly. `done` is high for exactly cycle N+2.
- R6: A `start` that arrives while `busy` is high is ignored. The running operation keeps its length and addresses and writes exactly N results.
- R7: A length of zero raises `done` in cycle 1 with `busy` low, and it issues no read and no write.
- R8: After reset, `busy`, `done`, both read enables and the write enable are low.
- R9: Addresses use unit stride from the latched bases, wrapping modulo 2^AW. Element k reads `base_x+k` and `base_y+k`, and its result is written to `base_z+k`.
- R10: A `start` sampled in the `done` cycle is accepted, so operations can run back to back with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts an operation when `busy` is low |
| len | input | LW | Number of elements, latched at start |
| base_x | input | AW | First address of operand vector X |
| base_y | input | AW | First address of operand vector Y |
| base_z | input | AW | First address of result vector Z |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdx_en | output | 1 | Read request on the X port |
| rdx_addr | output | AW | Read address on the X port |
| rdx_data | input | DW | X data, valid one cycle after the request |
| rdy_en | output | 1 | Read request on the Y port |
| rdy_addr | output | AW | Read address on the Y port |
| rdy_data | input | DW | Y data, valid one cycle after the request |
| wr_en | output | 1 | Write request on the Z port |
| wr_addr | output | AW | Write address on the Z port |
| wr_data | output | DW | Result word |

## Verification
A full 40-element vector exercises the steady-state overlap of load, add and store. Lengths of one and two separate the prologue and epilogue from the loop body, and a length of zero checks the empty path. Operand pairs that overflow (0xFFFF+1 and 0x8000+0x8000) distinguish wrapping addition from addition that keeps the carry. Bases near the top of the address space check address wrap. A `start` pulsed in mid-run, and a `start` placed in the `done` cycle, separate the rule that ignores `start` while busy from back-to-back acceptance.

// File: rtl/vadd_pkg.sv
package vadd_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_PRO,
    PH_LOOP,
    PH_EPI
  } phase_t;

endpackage

// File: rtl/vadd_loop_ctl.sv
module vadd_loop_ctl
  import vadd_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] len,
  output logic          start_acc,
  output logic          rd_fire,
  output logic          wr_fire,
  output logic          busy,
  output logic          done
);

  phase_t        phase;
  logic [LW-1:0] remain;
  logic          done_q;

  assign busy      = (phase != PH_IDLE);
  assign start_acc = start && !busy;
  assign rd_fire   = (phase == PH_PRO) || (phase == PH_LOOP);
  assign wr_fire   = (phase == PH_LOOP) || (phase == PH_EPI);
  assign done      = done_q;

  // Hardware loop: remain counts loop-body cycles still to run.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      remain <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (start_acc) begin
            if (len == '0) begin
              done_q <= 1'b1;
            end else begin
              phase  <= PH_PRO;
              remain <= len - LW'(1);
            end
          end
        end
        PH_PRO: begin
          phase <= (remain == '0) ? PH_EPI : PH_LOOP;
        end
        PH_LOOP: begin
          remain <= remain - LW'(1);
          if (remain == LW'(1)) phase <= PH_EPI;
        end
        PH_EPI: begin
          phase  <= PH_IDLE;
          done_q <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R5: the epilogue is followed by exactly one done cycle with busy low
  p_epi_then_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EPI) |=> (done && !busy))
    else $error("p_epi_then_done_r5");

  // R6: once busy, only the epilogue may end the run
  p_busy_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase != PH_EPI) |=> busy)
    else $error("p_busy_holds_r6");

endmodule

// File: rtl/vadd_addr_gen.sv
module vadd_addr_gen #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_acc,
  input  logic          rd_fire,
  input  logic          wr_fire,
  input  logic [AW-1:0] base_x,
  input  logic [AW-1:0] base_y,
  input  logic [AW-1:0] base_z,
  output logic [AW-1:0] rd_x,
  output logic [AW-1:0] rd_y,
  output logic [AW-1:0] wr_z
);

  logic [AW-1:0] bx_q, by_q, bz_q;
  logic [AW-1:0] ridx, widx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bx_q <= '0;
      by_q <= '0;
      bz_q <= '0;
      ridx <= '0;
      widx <= '0;
    end else if (start_acc) begin
      bx_q <= base_x;
      by_q <= base_y;
      bz_q <= base_z;
      ridx <= '0;
      widx <= '0;
    end else begin
      if (rd_fire) ridx <= ridx + AW'(1);
      // write index trails the read index by the one-cycle read latency
      if (wr_fire) widx <= widx + AW'(1);
    end
  end

  assign rd_x = bx_q + ridx;
  assign rd_y = by_q + ridx;
  assign wr_z = bz_q + widx;

  // R9: consecutive reads step by one word
  p_rd_stride_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && $past(rd_fire)) |-> (rd_x == AW'($past(rd_x) + AW'(1))))
    else $error("p_rd_stride_r9");

  // R9: consecutive writes step by one word
  p_wr_stride_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && $past(wr_fire)) |-> (wr_z == AW'($past(wr_z) + AW'(1))))
    else $error("p_wr_stride_r9");

endmodule

// File: rtl/vadd_datapath.sv
module vadd_datapath #(
  parameter int DW = 16
) (
  input  logic          wr_fire,
  input  logic [DW-1:0] op_x,
  input  logic [DW-1:0] op_y,
  output logic          wr_en,
  output logic [DW-1:0] wr_data
);

  // Modulo 2^DW sum, carry out dropped.
  always_comb begin
    wr_en   = wr_fire;
    wr_data = op_x + op_y;
  end

endmodule

// File: rtl/vadd_engine.sv
module vadd_engine #(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] len,
  input  logic [AW-1:0] base_x,
  input  logic [AW-1:0] base_y,
  input  logic [AW-1:0] base_z,
  output logic          busy,
  output logic          done,
  output logic          rdx_en,
  output logic [AW-1:0] rdx_addr,
  input  logic [DW-1:0] rdx_data,
  output logic          rdy_en,
  output logic [AW-1:0] rdy_addr,
  input  logic [DW-1:0] rdy_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  logic start_acc, rd_fire, wr_fire;

  vadd_loop_ctl #(.LW(LW)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .len       (len),
    .start_acc (start_acc),
    .rd_fire   (rd_fire),
    .wr_fire   (wr_fire),
    .busy      (busy),
    .done      (done)
  );

  vadd_addr_gen #(.AW(AW)) u_agen (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_acc (start_acc),
    .rd_fire   (rd_fire),
    .wr_fire   (wr_fire),
    .base_x    (base_x),
    .base_y    (base_y),
    .base_z    (base_z),
    .rd_x      (rdx_addr),
    .rd_y      (rdy_addr),
    .wr_z      (wr_addr)
  );

  vadd_datapath #(.DW(DW)) u_dp (
    .wr_fire (wr_fire),
    .op_x    (rdx_data),
    .op_y    (rdy_data),
    .wr_en   (wr_en),
    .wr_data (wr_data)
  );

  assign rdx_en = rd_fire;
  assign rdy_en = rd_fire;

  // R2: the first busy cycle loads both operands and stores nothing
  p_prologue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (rdx_en && rdy_en && !wr_en))
    else $error("p_prologue_r2");

  // R3: every store consumes a pair read in the previous cycle
  p_wr_follows_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(rdx_en) && $past(rdy_en)))
    else $error("p_wr_follows_rd_r3");

  // R4: a store with no read in the same cycle ends the run
  p_epilogue_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rdx_en) |=> done)
    else $error("p_epilogue_r4");

  // R7: an empty vector completes at once with no memory traffic
  p_zero_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && len == '0) |=> (done && !busy && !rdx_en && !rdy_en && !wr_en))
    else $error("p_zero_len_r7");

endmodule

// File: tb/vadd_engine_tb.sv
`timescale 1ns/1ps
module vadd_engine_tb;

  localparam int DW = 16;
  localparam int AW = 8;
  localparam int LW = 8;
  localparam int MEM = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [LW-1:0] len = '0;
  logic [AW-1:0] base_x = '0, base_y = '0, base_z = '0;
  logic          busy, done;
  logic          rdx_en, rdy_en, wr_en;
  logic [AW-1:0] rdx_addr, rdy_addr, wr_addr;
  logic [DW-1:0] rdx_data, rdy_data, wr_data;

  logic [DW-1:0] mx [MEM];
  logic [DW-1:0] my [MEM];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int wcount = 0;

  // reference model state
  bit m_act = 0;
  int m_t = 0, m_n = 0, m_bx = 0, m_by = 0, m_bz = 0;

  always #2.5 clk = ~clk;

  vadd_engine #(.DW(DW), .AW(AW), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len),
    .base_x(base_x), .base_y(base_y), .base_z(base_z),
    .busy(busy), .done(done),
    .rdx_en(rdx_en), .rdx_addr(rdx_addr), .rdx_data(rdx_data),
    .rdy_en(rdy_en), .rdy_addr(rdy_addr), .rdy_data(rdy_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // memories with one-cycle read latency
  always @(posedge clk) begin
    if (rdx_en) rdx_data <= mx[rdx_addr];
    if (rdy_en) rdy_data <= my[rdy_addr];
    if (rst_n && wr_en) wcount++;
  end

  // behavioural model: m_t counts cycles since the accepting edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_act = 0;
      m_t = 0;
    end else begin
      bit ebusy;
      ebusy = m_act && m_n > 0 && m_t >= 1 && m_t <= m_n + 1;
      if (!ebusy && start) begin
        m_act = 1;
        m_t = 1;
        m_n = int'(len);
        m_bx = int'(base_x);
        m_by = int'(base_y);
        m_bz = int'(base_z);
      end else if (m_act) begin
        m_t++;
        if (m_t > ((m_n == 0) ? 1 : m_n + 2)) m_act = 0;
      end
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_rd, e_wr, e_busy, e_done;
      int k, e_sum;
      string tg;
      e_rd   = m_act && m_n > 0 && m_t >= 1 && m_t <= m_n;
      e_wr   = m_act && m_n > 0 && m_t >= 2 && m_t <= m_n + 1;
      e_busy = m_act && m_n > 0 && m_t >= 1 && m_t <= m_n + 1;
      e_done = m_act && ((m_n == 0) ? (m_t == 1) : (m_t == m_n + 2));
      if (!m_act) tg = "R6";
      else if (m_n == 0) tg = "R7";
      else if (m_t == 1) tg = "R2";
      else if (m_t <= m_n) tg = "R3";
      else if (m_t == m_n + 1) tg = "R4";
      else tg = "R5";
      chk(rdx_en == e_rd, tg, "rdx_en", int'(rdx_en), int'(e_rd));
      chk(rdy_en == e_rd, tg, "rdy_en", int'(rdy_en), int'(e_rd));
      chk(wr_en == e_wr, tg, "wr_en", int'(wr_en), int'(e_wr));
      chk(busy == e_busy, "R5", "busy", int'(busy), int'(e_busy));
      chk(done == e_done, "R5", "done", int'(done), int'(e_done));
      if (e_rd) begin
        k = m_t - 1;
        chk(int'(rdx_addr) == (m_bx + k) % MEM, "R9", "rdx_addr", int'(rdx_addr), (m_bx + k) % MEM);
        chk(int'(rdy_addr) == (m_by + k) % MEM, "R9", "rdy_addr", int'(rdy_addr), (m_by + k) % MEM);
      end
      if (e_wr) begin
        k = m_t - 2;
        e_sum = (int'(mx[(m_bx + k) % MEM]) + int'(my[(m_by + k) % MEM])) % 65536;
        chk(int'(wr_addr) == (m_bz + k) % MEM, "R9", "wr_addr", int'(wr_addr), (m_bz + k) % MEM);
        chk(int'(wr_data) == e_sum, "R1", "wr_data", int'(wr_data), e_sum);
      end
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (m_act) @(negedge clk);
  endtask

  task automatic kick(input int bx, input int by, input int bz, input int n);
    @(negedge clk);
    base_x = AW'(bx);
    base_y = AW'(by);
    base_z = AW'(bz);
    len = LW'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input int bx, input int by, input int bz, input int n, input string tag);
    @(negedge clk);
    wcount = 0;
    kick(bx, by, bz, n);
    wait_idle();
    chk(wcount == n, tag, "write count", wcount, n);
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 50000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MEM; i++) begin
      mx[i] = DW'((i * 397 + 11) ^ 16'h5a3c);
      my[i] = DW'((i * 1213 + 7) ^ 16'h0f81);
    end
    // R1 overflow pairs inside the main vector
    mx[5] = 16'hffff; my[5] = 16'h0001;
    mx[6] = 16'h8000; my[6] = 16'h8000;
    mx[7] = 16'hfffe; my[7] = 16'hffff;

    repeat (3) @(negedge clk);
    // R8: reset state
    chk(!busy, "R8", "busy in reset", int'(busy), 0);
    chk(!done, "R8", "done in reset", int'(done), 0);
    chk(!rdx_en && !rdy_en, "R8", "read enables in reset", int'(rdx_en), 0);
    chk(!wr_en, "R8", "wr_en in reset", int'(wr_en), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(0, 0, 100, 40, "R4");     // main vector: R1 R2 R3 R4 R5
    run(10, 20, 200, 1, "R4");    // no loop body
    run(30, 40, 60, 2, "R4");     // single loop iteration
    run(0, 0, 0, 0, "R7");        // empty vector

    // R6: start with different settings while busy is ignored
    @(negedge clk);
    wcount = 0;
    kick(50, 60, 70, 8);
    @(negedge clk);
    base_x = 8'd1; base_y = 8'd2; base_z = 8'd3; len = 8'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    chk(wcount == 8, "R6", "write count after ignored start", wcount, 8);

    // R10: start placed in the done cycle is accepted
    @(negedge clk);
    wcount = 0;
    kick(80, 90, 110, 3);
    while (!done) @(negedge clk);
    base_x = 8'd120; base_y = 8'd130; base_z = 8'd140; len = 8'd4;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10", "busy after back-to-back start", int'(busy), 1);
    wait_idle();
    chk(wcount == 7, "R10", "write count back to back", wcount, 7);

    // R9: addresses wrap at the top of the space
    run(250, 252, 254, 12, "R9");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule